// File: doc/BRIEF.md
# Framed Packet Request Generator

This block turns a payload held in a local staging RAM into a single framed packet on a 64-bit streaming request port. A control side supplies a byte length, a transaction-type code and destination and source identifiers, then pulses a start input. The block streams an optional header word followed by the payload words read from the RAM. It drives active-low first-beat, last-beat, valid and per-lane byte-enable strobes against an active-low ready input.

The RAM is external and synchronous. The block asserts a read enable with a word address. The RAM returns that word on the following cycle and keeps its output unchanged while the read enable is low. Reads are issued ahead of need, so a packet flows with no gaps while ready is held low. A one-cycle done pulse marks the acceptance of the final beat. A parameter selects whether the header word is sent. Without the header, a packet of eight bytes or fewer is a single beat.

Top module: `pkt_req_gen`

## Requirements
- R1: With the header enabled (default), the first beat carries the header word: type code in bits [63:60], destination id in [59:52], source id in [51:44], byte length in [8:0], and all other bits zero. All byte enables are low on this beat.
- R2: Payload beats follow in order, carrying RAM words 0, 1, 2 and so on. There are ceil(length/8) of them.
- R3: Start-of-frame is low only on the first beat of a packet and end-of-frame only on its last beat. Without the header, a packet of 1 to 8 bytes has both low on its only beat.
- R4: Valid is low on every cycle from the first beat until the last beat is accepted, with no gap. A beat transfers on a clock edge where valid and ready are both low.
- R5: While ready is high during a packet, data, byte enables, start-of-frame, end-of-frame and valid hold their values.
- R6: Byte lane i is bits [8i+7:8i], and its enable bit i is active-low. On the last payload beat, lanes 0 to n-1 are enabled and the rest are disabled (high), where n = length mod 8 and 0 means all 8. Every other beat has all lanes enabled.
- R7: Busy is high from the cycle after an accepted start until the last beat is accepted. Done is high for exactly the one cycle that follows that acceptance.
- R8: A start pulse that arrives while busy is ignored. The packet in progress keeps its length and fields.
- R9: A start with a length of 0 or above 256 is ignored: no packet begins and busy stays low.
- R10: Reset asserts asynchronously and releases after two clock edges. While reset is asserted, every active-low output is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a packet |
| len_bytes | input | 9 | Payload length in bytes, 1 to 256 |
| txn_type | input | 4 | Transaction-type code placed in the header |
| dst_id | input | 8 | Destination identifier |
| src_id | input | 8 | Source identifier |
| ram_rd_en | output | 1 | Staging RAM read enable |
| ram_addr | output | 5 | Staging RAM word address |
| ram_rdata | input | 64 | Staging RAM read data, one cycle after the read |
| req_sof_n | output | 1 | Active-low first-beat marker |
| req_eof_n | output | 1 | Active-low last-beat marker |
| req_vld_n | output | 1 | Active-low beat valid |
| req_rdy_n | input | 1 | Active-low ready from the consumer |
| req_data | output | 64 | Beat data |
| req_be_n | output | 8 | Active-low byte enables, bit i for lane i |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
A start sampled on one clock edge puts the first beat on the port right after that edge, and busy rises at the same moment. Each later beat appears right after the edge that accepted the one before it. Done appears right after the edge that accepted the last beat and is gone one edge later. Reset release takes two edges. The bench drives inputs and samples outputs on the falling clock edge, so each check reads the state left by the rising edge before it. When a stall precedes a sample, the bench compares against the values it stored before the stall.

// File: rtl/pkt_req_pkg.sv
package pkt_req_pkg;

   // Role of the beat currently presented on the request port
   typedef enum logic [1:0] {
      BEAT_IDLE = 2'd0,
      BEAT_HDR  = 2'd1,
      BEAT_PAY  = 2'd2,
      BEAT_LAST = 2'd3
   } beat_kind_e;

endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_sync_n
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pkt_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
   end

   assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pkt_beat_ctrl.sv
module pkt_beat_ctrl
   import pkt_req_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int MAX_LEN = 256,
   parameter int HDR_EN  = 1,
   localparam int LEN_W   = $clog2(MAX_LEN + 1),
   localparam int PAY_MAX = MAX_LEN / LANES,
   localparam int ADDR_W  = $clog2(PAY_MAX),
   localparam int BEAT_W  = $clog2(PAY_MAX + 2),
   localparam int LSB_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len,
   input  logic              rdy_n,
   output logic              start_ok,
   output logic              busy,
   output beat_kind_e        kind,
   output logic              sof_n,
   output logic              eof_n,
   output logic              vld_n,
   output logic              done,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_addr
);

   localparam logic [LEN_W-1:0] MAX_LEN_V = LEN_W'(MAX_LEN);
   localparam logic [BEAT_W-1:0] HDR_V    = BEAT_W'(HDR_EN);

   logic              busy_q;
   logic              done_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] last_q;
   logic [ADDR_W-1:0] rd_ptr_q;

   logic [LEN_W:0]    len_up;
   logic [LEN_W:0]    pay_w;
   logic [BEAT_W-1:0] last_idx;
   logic              len_ok;
   logic              adv;
   logic              at_first;
   logic              at_last;
   logic              is_pay;

   assign len_ok   = (len != '0) && (len <= MAX_LEN_V);
   assign start_ok = start && !busy_q && len_ok;

   // beats in the packet: optional header plus ceil(len/LANES) payload words
   assign len_up   = {1'b0, len} + (LEN_W + 1)'(LANES - 1);
   assign pay_w    = len_up >> LSB_W;
   assign last_idx = BEAT_W'(pay_w) + HDR_V - BEAT_W'(1);

   assign adv      = busy_q && !rdy_n;
   assign at_first = (beat_q == '0);
   assign at_last  = (beat_q == last_q);
   assign is_pay   = (HDR_EN == 0) || !at_first;

   // word 0 is read at start; each accepted payload beat prefetches the next
   assign ram_rd_en = start_ok || (adv && is_pay && !at_last);
   assign ram_addr  = start_ok ? '0 : rd_ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         beat_q   <= '0;
         last_q   <= '0;
         rd_ptr_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_ok) begin
            busy_q   <= 1'b1;
            beat_q   <= '0;
            last_q   <= last_idx;
            rd_ptr_q <= ADDR_W'(1);
         end else if (adv) begin
            if (at_last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               beat_q <= beat_q + BEAT_W'(1);
               if (is_pay) rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
            end
         end
      end
   end

   always_comb begin
      if (!busy_q)                         kind = BEAT_IDLE;
      else if ((HDR_EN != 0) && at_first) kind = BEAT_HDR;
      else if (at_last)                    kind = BEAT_LAST;
      else                                 kind = BEAT_PAY;
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign vld_n = !busy_q;
   assign sof_n = !(busy_q && at_first);
   assign eof_n = !(busy_q && at_last);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(busy_q && at_last && !rdy_n));

   // R8
   hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !(adv && at_last)) |=> (busy_q && $stable(last_q)));

   // R5
   stall_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rdy_n) |=> (busy_q && $stable(beat_q)));

endmodule

// File: rtl/pkt_lane_mask.sv
module pkt_lane_mask
   import pkt_req_pkg::*;
#(
   parameter int LANES = 8,
   localparam int LSB_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  beat_kind_e       kind,
   input  logic [LSB_W-1:0] len_lsb,
   output logic [LANES-1:0] be_n
);

   logic partial;

   // a remainder of zero means the last beat is completely filled
   assign partial = (kind == BEAT_LAST) && (len_lsb != '0);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign be_n[i] = (kind == BEAT_IDLE) ||
                          (partial && (len_lsb <= LSB_W'(i)));
      end
   endgenerate

   // R6
   lane0_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != BEAT_IDLE) |-> !be_n[0]);

   // R6
   full_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == BEAT_HDR) || (kind == BEAT_PAY)) |-> (be_n == '0));

endmodule

// File: rtl/pkt_req_gen.sv
module pkt_req_gen
   import pkt_req_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int MAX_LEN    = 256,
   parameter int TYPE_W     = 4,
   parameter int ID_W       = 8,
   parameter int HDR_EN     = 1,
   parameter int RST_STAGES = 2,
   localparam int LANES  = DATA_W / 8,
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int ADDR_W = $clog2(MAX_LEN / LANES),
   localparam int LSB_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  len_bytes,
   input  logic [TYPE_W-1:0] txn_type,
   input  logic [ID_W-1:0]   dst_id,
   input  logic [ID_W-1:0]   src_id,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              req_sof_n,
   output logic              req_eof_n,
   output logic              req_vld_n,
   input  logic              req_rdy_n,
   output logic [DATA_W-1:0] req_data,
   output logic [LANES-1:0]  req_be_n,
   output logic              busy,
   output logic              done
);

   generate
      if ((DATA_W % 8) != 0 || LANES < 2) begin : g_bad_width
         $error("pkt_req_gen: DATA_W must be a multiple of 8 with at least 2 lanes");
      end
      if ((MAX_LEN % LANES) != 0 || MAX_LEN < 2 * LANES) begin : g_bad_len
         $error("pkt_req_gen: MAX_LEN must be a multiple of the lane count, at least two words");
      end
      if (TYPE_W + 2 * ID_W + LEN_W > DATA_W) begin : g_bad_hdr
         $error("pkt_req_gen: header fields do not fit the data width");
      end
      if (HDR_EN != 0 && HDR_EN != 1) begin : g_bad_hdr_en
         $error("pkt_req_gen: HDR_EN must be 0 or 1");
      end
   endgenerate

   logic       rst_s_n;
   logic       start_ok;
   beat_kind_e kind;

   logic [LEN_W-1:0]  len_q;
   logic [TYPE_W-1:0] type_q;
   logic [ID_W-1:0]   dst_q;
   logic [ID_W-1:0]   src_q;

   pkt_rst_sync #(
      .STAGES (RST_STAGES)
   ) u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (rst_s_n)
   );

   pkt_beat_ctrl #(
      .LANES   (LANES),
      .MAX_LEN (MAX_LEN),
      .HDR_EN  (HDR_EN)
   ) u_beat_ctrl (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .start     (start),
      .len       (len_bytes),
      .rdy_n     (req_rdy_n),
      .start_ok  (start_ok),
      .busy      (busy),
      .kind      (kind),
      .sof_n     (req_sof_n),
      .eof_n     (req_eof_n),
      .vld_n     (req_vld_n),
      .done      (done),
      .ram_rd_en (ram_rd_en),
      .ram_addr  (ram_addr)
   );

   // packet fields are latched only on an accepted start
   always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
         len_q  <= '0;
         type_q <= '0;
         dst_q  <= '0;
         src_q  <= '0;
      end else if (start_ok) begin
         len_q  <= len_bytes;
         type_q <= txn_type;
         dst_q  <= dst_id;
         src_q  <= src_id;
      end
   end

   pkt_lane_mask #(
      .LANES (LANES)
   ) u_lane_mask (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .kind    (kind),
      .len_lsb (len_q[LSB_W-1:0]),
      .be_n    (req_be_n)
   );

   generate
      if (HDR_EN != 0) begin : g_hdr
         logic [DATA_W-1:0] hdr_word;
         always_comb begin
            hdr_word = '0;
            hdr_word[DATA_W-1 -: TYPE_W]             = type_q;
            hdr_word[DATA_W-1-TYPE_W -: ID_W]        = dst_q;
            hdr_word[DATA_W-1-TYPE_W-ID_W -: ID_W]   = src_q;
            hdr_word[LEN_W-1:0]                      = len_q;
         end
         always_comb begin
            case (kind)
               BEAT_IDLE: req_data = '0;
               BEAT_HDR:  req_data = hdr_word;
               default:   req_data = ram_rdata;
            endcase
         end
      end else begin : g_raw
         assign req_data = (kind == BEAT_IDLE) ? '0 : ram_rdata;
      end
   endgenerate

   // R5
   hold_port_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (!req_vld_n && req_rdy_n) |=> (!req_vld_n && $stable(req_data) &&
         $stable(req_be_n) && $stable(req_sof_n) && $stable(req_eof_n)));

   // R3
   frame_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (!req_sof_n || !req_eof_n) |-> !req_vld_n);

   // R4
   no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      (!req_vld_n && req_eof_n) |=> !req_vld_n);

   // R10
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      req_vld_n |-> (req_sof_n && req_eof_n && (&req_be_n)));

endmodule

// File: tb/pkt_req_gen_bench.sv
module pkt_req_gen_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        start_a, start_b;
   logic [8:0]  len_bytes;
   logic [3:0]  txn_type;
   logic [7:0]  dst_id, src_id;
   logic        rdy_n;

   logic        rd_en_a, rd_en_b;
   logic [4:0]  addr_a, addr_b;
   logic [63:0] rdata_a, rdata_b;
   logic        sof_a, eof_a, vld_a, busy_a, done_a;
   logic        sof_b, eof_b, vld_b, busy_b, done_b;
   logic [63:0] data_a, data_b;
   logic [7:0]  be_a, be_b;

   int checks = 0;
   int errors = 0;
   bit sel = 0;
   bit finished = 0;

   function automatic logic [63:0] pat(int i);
      return {8'hC3 ^ 8'(i), 24'h5A_0F00 + 24'(i), 32'h1234_0000 + 32'(i * 3)};
   endfunction

   always_ff @(posedge clk) if (rd_en_a) rdata_a <= pat(int'(addr_a));
   always_ff @(posedge clk) if (rd_en_b) rdata_b <= pat(int'(addr_b));

   pkt_req_gen u_pkt_req_gen (
      .clk(clk), .rst_n(rst_n), .start(start_a), .len_bytes(len_bytes),
      .txn_type(txn_type), .dst_id(dst_id), .src_id(src_id),
      .ram_rd_en(rd_en_a), .ram_addr(addr_a), .ram_rdata(rdata_a),
      .req_sof_n(sof_a), .req_eof_n(eof_a), .req_vld_n(vld_a), .req_rdy_n(rdy_n),
      .req_data(data_a), .req_be_n(be_a), .busy(busy_a), .done(done_a));

   pkt_req_gen #(.HDR_EN(0)) u_pkt_req_gen_raw (
      .clk(clk), .rst_n(rst_n), .start(start_b), .len_bytes(len_bytes),
      .txn_type(txn_type), .dst_id(dst_id), .src_id(src_id),
      .ram_rd_en(rd_en_b), .ram_addr(addr_b), .ram_rdata(rdata_b),
      .req_sof_n(sof_b), .req_eof_n(eof_b), .req_vld_n(vld_b), .req_rdy_n(rdy_n),
      .req_data(data_b), .req_be_n(be_b), .busy(busy_b), .done(done_b));

   logic        c_sof, c_eof, c_vld, c_busy, c_done;
   logic [63:0] c_data;
   logic [7:0]  c_be;
   assign c_sof  = sel ? sof_b  : sof_a;
   assign c_eof  = sel ? eof_b  : eof_a;
   assign c_vld  = sel ? vld_b  : vld_a;
   assign c_busy = sel ? busy_b : busy_a;
   assign c_done = sel ? done_b : done_a;
   assign c_data = sel ? data_b : data_a;
   assign c_be   = sel ? be_b   : be_a;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input bit which);
      if (which) start_b = 1'b1; else start_a = 1'b1;
   endtask

   // one packet; mode 0 always ready, 1 stall every other cycle, 2 ready one cycle in three
   task automatic send(input bit which, input int len, input logic [3:0] ty,
                       input logic [7:0] dst, input logic [7:0] src,
                       input int mode, input bit inject);
      int hdr = which ? 0 : 1;
      int total = (len + 7) / 8 + hdr;
      int beat = 0;
      int cyc = 0;
      bit stalled = 0;
      bit inj_live = 0;
      logic [63:0] s_data;
      logic [7:0]  s_be;
      logic        s_sof, s_eof;
      sel = which;
      @(negedge clk);
      len_bytes = 9'(len); txn_type = ty; dst_id = dst; src_id = src;
      pulse_start(which);
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;
      chk(c_busy == 1'b1, "R7 busy after start", 64'(c_busy), 64'd1);
      while (beat < total && cyc < 5000) begin
         logic [63:0] e_data;
         logic [7:0]  e_be;
         int n;
         if (inj_live) begin
            start_a = 1'b0; start_b = 1'b0; inj_live = 0;
         end
         if (stalled) begin
            chk(c_data == s_data && c_be == s_be && c_sof == s_sof && c_eof == s_eof,
                "R5 hold during stall", c_data, s_data);
         end
         chk(c_vld == 1'b0, "R4 valid low in packet", 64'(c_vld), 64'd0);
         if (inject && beat == 2) begin
            len_bytes = 9'd8; dst_id = 8'hEE;
            pulse_start(which);
            inj_live = 1;
         end
         case (mode)
            1:       rdy_n = (cyc % 2) == 1;
            2:       rdy_n = (cyc % 3) != 2;
            default: rdy_n = 1'b0;
         endcase
         if (!rdy_n) begin
            e_data = (beat < hdr) ? {ty, dst, src, 35'd0, 9'(len)} : pat(beat - hdr);
            e_be = '0;
            n = len % 8;
            if (beat == total - 1 && beat >= hdr && n != 0)
               for (int i = 0; i < 8; i++) if (i >= n) e_be[i] = 1'b1;
            if (beat < hdr)
               chk(c_data == e_data, "R1 header word", c_data, e_data);
            else
               chk(c_data == e_data, "R2 payload word", c_data, e_data);
            chk(c_be == e_be, "R6 byte enables", 64'(c_be), 64'(e_be));
            chk(c_sof == (beat != 0), "R3 sof", 64'(c_sof), 64'(beat != 0));
            chk(c_eof == (beat != total - 1), "R3 eof", 64'(c_eof), 64'(beat != total - 1));
            beat++;
            stalled = 0;
         end else begin
            stalled = 1;
            s_data = c_data; s_be = c_be; s_sof = c_sof; s_eof = c_eof;
         end
         @(negedge clk);
         cyc++;
      end
      rdy_n = 1'b1;
      start_a = 1'b0; start_b = 1'b0;
      chk(c_done == 1'b1, "R7 done after last", 64'(c_done), 64'd1);
      chk(c_busy == 1'b0 && c_vld == 1'b1, "R7 idle after last",
          64'({c_busy, c_vld}), 64'b01);
      @(negedge clk);
      chk(c_done == 1'b0, "R7 done one cycle", 64'(c_done), 64'd0);
      chk(c_vld == 1'b1, "R8 no extra packet", 64'(c_vld), 64'd1);
   endtask

   task automatic bad_len(input int len);
      sel = 0;
      @(negedge clk);
      len_bytes = 9'(len);
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      chk(busy_a == 1'b0 && vld_a == 1'b1 && sof_a == 1'b1, "R9 bad length ignored",
          64'({busy_a, vld_a, sof_a}), 64'b011);
   endtask

   task automatic reset_state(input string tag);
      chk(sof_a && eof_a && vld_a && (&be_a) && !done_a &&
          sof_b && eof_b && vld_b && (&be_b) && !done_b, tag,
          64'({sof_a, eof_a, vld_a, be_a, done_a}), 64'({3'b111, 8'hFF, 1'b0}));
   endtask

   task automatic mid_reset();
      sel = 0;
      @(negedge clk);
      len_bytes = 9'd100; txn_type = 4'h2; dst_id = 8'h11; src_id = 8'h11;
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      rdy_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      reset_state("R10 async reset mid packet");
      rdy_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_state("R10 held one edge after release");
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start_a = 1'b0; start_b = 1'b0; rdy_n = 1'b1;
      len_bytes = '0; txn_type = '0; dst_id = '0; src_id = '0;
      repeat (3) @(negedge clk);
      reset_state("R10 reset state");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      send(0, 17,  4'h5, 8'h42, 8'h42, 0, 0);
      send(0, 64,  4'hA, 8'h07, 8'h07, 1, 0);
      send(0, 256, 4'hF, 8'hFF, 8'hFF, 2, 0);
      send(1, 5,   4'h1, 8'h33, 8'h33, 0, 0);
      send(1, 8,   4'h1, 8'h33, 8'h33, 1, 0);
      send(1, 23,  4'h3, 8'h90, 8'h90, 2, 0);
      send(0, 40,  4'h6, 8'h21, 8'h21, 1, 1);
      send(1, 30,  4'h6, 8'h21, 8'h21, 0, 1);
      bad_len(0);
      bad_len(257);
      bad_len(300);
      mid_reset();
      send(0, 9, 4'hC, 8'h5D, 8'h5D, 0, 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule